// File: doc/BRIEF.md
# Fractional-N Divider Modulus Controller

This block chooses, once per divided-VCO cycle, the integer division value handed to a dual-modulus pulse-swallow feedback divider. The programmed setting is a prescaler size (8 or 6, picked by a device-select bit), a B counter, an A swallow count and an 11-bit fractional numerator. The base integer ratio is prescaler × B + A. A second-order error-feedback modulator then adds a small signed offset on each cycle, so that the long-run average ratio is base + FN / M.

The fractional modulus M is not a power of two. It is 1920 when the reference-select bit is 0 (a 19.20 MHz reference) and 1968 when it is 1 (19.68 MHz), so that one numerator step is always 10 kHz of output frequency. Both accumulators wrap at M. A new setting is taken on a `load` strobe. A legal setting clears the modulator, so a frequency change starts from a known state. An illegal setting raises an error flag and leaves the previous setting running.

Top module: `fracn_modulus_ctrl`

## Requirements
- R1: After reset the output is 16 (prescaler 8, B = 2, A = 0, FN = 0, M = 1920) and `cfg_err` is 0.
- R2: `dev_sel` = 1 selects a prescaler of 8; `dev_sel` = 0 selects a prescaler of 6. The base ratio is prescaler × B + A.
- R3: `ref_sel` = 0 selects M = 1920; `ref_sel` = 1 selects M = 1968. Both modulator accumulators stay below M.
- R4: A legal `load` clears both accumulators and the delayed carry. On the next clock, `n_div` equals the new base ratio and `cfg_err` is 0.
- R5: Every output lies between base − 1 and base + 2, inclusive.
- R6: After a legal load, take each aligned block of M consecutive outputs that follows the load output. Each such block sums to exactly M × base + FN.
- R7: With FN = 0, every output equals the base ratio.
- R8: A load is illegal if any of these holds: B < 2, A ≥ B, A > 7 with prescaler 8, A > 5 with prescaler 6, or FN ≥ M. An illegal load sets `cfg_err` on the next clock. The previously loaded setting keeps driving `n_div`.
- R9: `cfg_err` stays set until a legal load, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided-VCO clock; one output value per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Take the setting on the inputs at this edge |
| dev_sel | input | 1 | Prescaler select: 1 = 8, 0 = 6 |
| ref_sel | input | 1 | Modulus select: 0 = 1920, 1 = 1968 |
| b_val | input | 4 | B counter value |
| a_val | input | 3 | A swallow count |
| frac_num | input | 11 | Fractional numerator FN |
| n_div | output | 8 | Integer division value for this cycle |
| cfg_err | output | 1 | Last load was illegal |

## Verification
The bench builds the block with its default parameters: prescalers of 8 and 6, and moduli of 1920 and 1968. At these sizes a full modulus period is under two thousand cycles. The bench can therefore sweep all four prescaler and modulus pairings with numerators of zero, one, M − 1 and mid-range values, and sum two complete aligned periods after each load to check the exact fractional total. It also checks every output against its window. The same build reaches every illegal-range edge: B = 1, A equal to B, A = 6 with the small prescaler, and FN equal to either modulus.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    localparam int FRAC_W = 11;
    localparam int B_W    = 4;
    localparam int A_W    = 3;
    localparam int N_W    = 8;
    localparam int STAGES = 2;

    typedef struct packed {
        logic [N_W-1:0]    base;
        logic [FRAC_W-1:0] frac;
        logic [FRAC_W-1:0] modulus;
    } fracn_cfg_t;

    typedef struct packed {
        fracn_cfg_t                    cfg;
        logic [STAGES-1:0][FRAC_W-1:0] acc;
        logic                          c2_dly;
        logic [N_W-1:0]                n;
        logic                          err;
    } fracn_state_t;
endpackage

// File: rtl/fracn_cfg_check.sv
module fracn_cfg_check
    import fracn_pkg::*;
#(
    parameter int PRE_HI   = 8,
    parameter int PRE_LO   = 6,
    parameter int A_MAX_HI = 7,
    parameter int A_MAX_LO = 5,
    parameter int MOD_HI   = 1968,
    parameter int MOD_LO   = 1920
) (
    input  logic              dev_sel,
    input  logic              ref_sel,
    input  logic [B_W-1:0]    b_val,
    input  logic [A_W-1:0]    a_val,
    input  logic [FRAC_W-1:0] frac_val,
    output fracn_cfg_t        cand,
    output logic              legal
);
    logic [N_W-1:0]    pre;
    logic [A_W-1:0]    a_max;
    logic [FRAC_W-1:0] modv;

    always_comb begin
        pre          = dev_sel ? N_W'(PRE_HI) : N_W'(PRE_LO);
        a_max        = dev_sel ? A_W'(A_MAX_HI) : A_W'(A_MAX_LO);
        modv         = ref_sel ? FRAC_W'(MOD_HI) : FRAC_W'(MOD_LO);
        cand.base    = N_W'(pre * N_W'(b_val)) + N_W'(a_val);
        cand.frac    = frac_val;
        cand.modulus = modv;
        // R8: every range rule must hold for the setting to be taken
        legal        = (b_val >= B_W'(2)) && (B_W'(a_val) < b_val) &&
                       (a_val <= a_max) && (frac_val < modv);
    end
endmodule

// File: rtl/fracn_acc_stage.sv
module fracn_acc_stage
    import fracn_pkg::*;
(
    input  logic [FRAC_W-1:0] acc_q,
    input  logic [FRAC_W-1:0] inc,
    input  logic [FRAC_W-1:0] modulus,
    output logic [FRAC_W-1:0] acc_next,
    output logic              carry
);
    logic [FRAC_W:0] sum;

    always_comb begin
        sum      = {1'b0, acc_q} + {1'b0, inc};
        carry    = (sum >= {1'b0, modulus});
        acc_next = carry ? FRAC_W'(sum - {1'b0, modulus}) : sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/fracn_modulus_ctrl.sv
module fracn_modulus_ctrl
    import fracn_pkg::*;
#(
    parameter int PRE_HI   = 8,
    parameter int PRE_LO   = 6,
    parameter int A_MAX_HI = 7,
    parameter int A_MAX_LO = 5,
    parameter int MOD_HI   = 1968,
    parameter int MOD_LO   = 1920
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              dev_sel,
    input  logic              ref_sel,
    input  logic [B_W-1:0]    b_val,
    input  logic [A_W-1:0]    a_val,
    input  logic [FRAC_W-1:0] frac_num,
    output logic [N_W-1:0]    n_div,
    output logic              cfg_err
);
    localparam logic [N_W-1:0] RST_BASE = N_W'(PRE_HI * 2);
    localparam fracn_state_t RST_ST = '{
        cfg:    '{base: RST_BASE, frac: '0, modulus: FRAC_W'(MOD_LO)},
        acc:    '0,
        c2_dly: 1'b0,
        n:      RST_BASE,
        err:    1'b0
    };

    fracn_state_t st_q, st_d;
    fracn_cfg_t   cand;
    logic         legal;

    logic [STAGES-1:0][FRAC_W-1:0] stg_inc;
    logic [STAGES-1:0][FRAC_W-1:0] stg_next;
    logic [STAGES-1:0]             stg_cy;

    fracn_cfg_check #(
        .PRE_HI(PRE_HI), .PRE_LO(PRE_LO), .A_MAX_HI(A_MAX_HI),
        .A_MAX_LO(A_MAX_LO), .MOD_HI(MOD_HI), .MOD_LO(MOD_LO)
    ) u_check (
        .dev_sel (dev_sel),
        .ref_sel (ref_sel),
        .b_val   (b_val),
        .a_val   (a_val),
        .frac_val(frac_num),
        .cand    (cand),
        .legal   (legal)
    );

    // Cascade of modulo-M accumulators: stage 0 integrates FN, later
    // stages integrate the residue of the stage before.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign stg_inc[s] = st_q.cfg.frac;
        end else begin : g_chain
            assign stg_inc[s] = stg_next[s-1];
        end
        fracn_acc_stage u_stage (
            .acc_q   (st_q.acc[s]),
            .inc     (stg_inc[s]),
            .modulus (st_q.cfg.modulus),
            .acc_next(stg_next[s]),
            .carry   (stg_cy[s])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.acc    = stg_next;
        st_d.c2_dly = stg_cy[STAGES-1];
        // offset = c1 + c2 - c2 delayed, range -1..+2
        st_d.n      = st_q.cfg.base + N_W'(stg_cy[0]) + N_W'(stg_cy[STAGES-1])
                      - N_W'(st_q.c2_dly);
        if (load) begin
            if (legal) begin
                st_d.cfg    = cand;
                st_d.acc    = '0;
                st_d.c2_dly = 1'b0;
                st_d.n      = cand.base;
                st_d.err    = 1'b0;
            end else begin
                st_d.err    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign n_div   = st_q.n;
    assign cfg_err = st_q.err;

    // R8: an illegal load raises the error flag on the next edge
    a_r8_err_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !legal) |=> cfg_err);

    // R4 / R9: a legal load restarts the modulator and clears the error
    a_r4_restart_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && legal) |=> (st_q.acc == '0 && !cfg_err && n_div == $past(cand.base)));

    // R3: accumulator residues stay below the selected modulus
    a_r3_acc_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc[0] < st_q.cfg.modulus) && (st_q.acc[STAGES-1] < st_q.cfg.modulus));

    // R5: output stays within the offset window around the base
    a_r5_offset_window: assert property (@(posedge clk) disable iff (!rst_n)
        ((({1'b0, n_div}) + (N_W+1)'(1)) >= {1'b0, st_q.cfg.base}) &&
        ({1'b0, n_div} <= ({1'b0, st_q.cfg.base} + (N_W+1)'(2))));

    // R7: with a zero numerator and an idle modulator the output is the base
    a_r7_integer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.frac == '0 && st_q.acc == '0 && !st_q.c2_dly && !load)
        |=> n_div == $past(st_q.cfg.base));
endmodule

// File: tb/fracn_modulus_ctrl_bench.sv
module fracn_modulus_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        dev_sel = 1'b0;
    logic        ref_sel = 1'b0;
    logic [3:0]  b_val = '0;
    logic [2:0]  a_val = '0;
    logic [10:0] frac_num = '0;
    logic [7:0]  n_div;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fracn_modulus_ctrl u_fracn_modulus_ctrl (
        .clk(clk), .rst_n(rst_n), .load(load), .dev_sel(dev_sel),
        .ref_sel(ref_sel), .b_val(b_val), .a_val(a_val),
        .frac_num(frac_num), .n_div(n_div), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_load(input bit d, input bit r, input int b, input int a, input int fn);
        @(negedge clk);
        dev_sel = d; ref_sel = r; b_val = 4'(b); a_val = 3'(a); frac_num = 11'(fn);
        load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
    endtask

    // Legal load followed by two aligned modulus periods
    task automatic run_window(input bit d, input bit r, input int b, input int a, input int fn);
        int pre, m, base;
        pre  = d ? 8 : 6;
        m    = r ? 1968 : 1920;
        base = pre * b + a;
        do_load(d, r, b, a, fn);
        check(n_div == 8'(base) && !cfg_err, "R4 load output (R2 base)", int'(n_div), base);
        for (int w = 0; w < 2; w++) begin
            int sum = 0;
            int bad = 0;
            int first_bad = 0;
            int const_bad = 0;
            for (int k = 0; k < m; k++) begin
                @(negedge clk);
                sum += int'(n_div);
                if (int'(n_div) < base - 1 || int'(n_div) > base + 2) begin
                    if (bad == 0) first_bad = int'(n_div);
                    bad++;
                end
                if (fn == 0 && int'(n_div) != base) const_bad++;
            end
            check(sum == m * base + fn, "R6 block sum (R3 modulus)", sum, m * base + fn);
            check(bad == 0, "R5 offset window", first_bad, base);
            if (fn == 0) check(const_bad == 0, "R7 integer constant", const_bad, 0);
        end
    endtask

    task automatic illegal_case(input bit d, input bit r, input int b, input int a, input int fn,
                                input int held_base);
        do_load(d, r, b, a, fn);
        check(cfg_err == 1'b1, "R8 error flag", int'(cfg_err), 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(n_div == 8'(held_base) && cfg_err, "R8 setting held / R9 sticky",
                  int'(n_div), held_base);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int fns[5];
        int idx = 0;
        repeat (3) @(negedge clk);
        check(n_div == 8'd16, "R1 reset output", int'(n_div), 16);
        check(cfg_err == 1'b0, "R1 reset error flag", int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(n_div == 8'd16, "R1 after reset release", int'(n_div), 16);

        for (int d = 0; d < 2; d++) begin
            for (int r = 0; r < 2; r++) begin
                int m = (r != 0) ? 1968 : 1920;
                int amax = (d != 0) ? 7 : 5;
                fns[0] = 0; fns[1] = 1; fns[2] = m - 1; fns[3] = m / 2 + 1; fns[4] = 1037;
                for (int f = 0; f < 5; f++) begin
                    int b = 2 + (idx * 3) % 14;
                    int a = idx % (amax + 1);
                    if (a >= b) a = b - 1;
                    run_window(d[0], r[0], b, a, fns[f]);
                    idx++;
                end
            end
        end
        // boundary settings: largest B and A for each prescaler
        run_window(1'b1, 1'b1, 15, 7, 1967);
        run_window(1'b0, 1'b0, 15, 5, 1919);

        // illegal loads against a held integer setting: 8*5+3 = 43
        do_load(1'b1, 1'b0, 5, 3, 0);
        check(n_div == 8'd43 && !cfg_err, "R4 reference setting", int'(n_div), 43);
        illegal_case(1'b1, 1'b0, 1, 0, 0, 43);      // B < 2
        illegal_case(1'b1, 1'b0, 4, 4, 0, 43);      // A == B
        illegal_case(1'b0, 1'b0, 9, 6, 0, 43);      // A > 5 with prescaler 6
        illegal_case(1'b1, 1'b0, 9, 2, 1920, 43);   // FN == M (1920)
        illegal_case(1'b1, 1'b1, 9, 2, 1968, 43);   // FN == M (1968)
        do_load(1'b0, 1'b1, 3, 2, 0);
        check(cfg_err == 1'b0, "R9 legal load clears error", int'(cfg_err), 0);
        check(n_div == 8'd20, "R9 new setting after clear", int'(n_div), 20);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule